// File: doc/BRIEF.md
# Programmable RGB Panel Raster Timing Generator

This block drives the timing side of a parallel RGB TFT panel. From a system clock it derives a pixel clock, and from a set of programmed intervals it walks every line through sync pulse, back porch, active pixels and front porch, and every frame through the same four segments counted in lines. It produces the horizontal and vertical sync pulses, a data-enable, the coordinates of the pixel being shown and a one-cycle request strobe that tells the pixel data path to supply the next pixel. Pixel data from that path is passed to the panel pins only during the active area.

All interval inputs are written as the wanted count minus one. The divider value sets the pixel clock to the system clock divided by twice the value plus one. Every panel-facing output has its own invert control, so panels that expect low-going syncs, a low data-enable, inverted data or capture on the other clock edge can be driven without extra logic. The full configuration is captured into a shadow copy only at the start of a frame (and continuously while stopped), so software may rewrite it at any time without tearing a frame.

Top module: `lcd_raster_gen`

## Requirements
- R1: The pixel clock period is 2*(CLKVAL+1) system clocks with a 50% duty cycle; with the clock invert bit at 0 it rises in the same system cycle that sync, data-enable, coordinates and data change, so the panel captures on its falling edge.
- R2: Each line is a sync pulse of (hsync_w_i+1) pixel clocks, then a back porch of (hback_i+1), then (hact_i+1) active pixels, then a front porch of (hfront_i+1); the next line's sync starts directly after the front porch.
- R3: Each frame is a vertical sync of (vsync_w_i+1) lines, then (vback_i+1) back-porch lines, then (vact_i+1) active lines, then (vfront_i+1) front-porch lines, in that order, with no gap before the next vertical sync.
- R4: Field widths are 10 bits for CLKVAL, 8 bits for the horizontal sync, back and front porch fields, 11 bits for the horizontal active field, 6 bits for the vertical sync field, 8 bits for the vertical porches and 10 bits for the vertical active field, each holding value minus one.
- R5: Data-enable is active only when both the line and the frame are in their active segments; x_o runs 0 to hact_i and y_o 0 to vact_i there, and both read 0 elsewhere.
- R6: req_o is high for exactly one system cycle at the start of every active pixel and never outside the active area.
- R7: Invert bits (pclk, hsync, vsync, data, data-enable) are each XORed onto their output; rgb_o carries rgb_i during data-enable and all zeros otherwise, before the data invert.
- R8: While en_i is 0, one system cycle after it is sampled low, every panel output sits at its inactive level after inversion, x_o and y_o are 0 and req_o is 0.
- R9: After en_i rises, the frame starts with vertical and horizontal sync both active and the pixel clock rising, CLKVAL+1 system clock edges after the first edge that samples en_i high.
- R10: Configuration and invert inputs are taken only at the boundary between frames (or while stopped); a change during a frame leaves that frame's timing unchanged and takes effect with the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable for timing and video output |
| clkval_i | input | 10 | Pixel clock divider value |
| hsync_w_i | input | 8 | Horizontal sync width minus one |
| hback_i | input | 8 | Horizontal back porch minus one |
| hact_i | input | 11 | Active pixels per line minus one |
| hfront_i | input | 8 | Horizontal front porch minus one |
| vsync_w_i | input | 6 | Vertical sync width in lines minus one |
| vback_i | input | 8 | Vertical back porch lines minus one |
| vact_i | input | 10 | Active lines minus one |
| vfront_i | input | 8 | Vertical front porch lines minus one |
| inv_pclk_i | input | 1 | Invert pixel clock |
| inv_hsync_i | input | 1 | Invert horizontal sync |
| inv_vsync_i | input | 1 | Invert vertical sync |
| inv_data_i | input | 1 | Invert pixel data |
| inv_de_i | input | 1 | Invert data-enable |
| rgb_i | input | 16 | Pixel data from the data path |
| pclk_o | output | 1 | Pixel clock to the panel |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data-enable |
| rgb_o | output | 16 | Pixel data to the panel |
| x_o | output | 11 | Current active column |
| y_o | output | 10 | Current active row |
| req_o | output | 1 | One-cycle request for the next pixel |

## Verification
The bench measures whole frames at the panel pins for several geometries, including single-pixel segments and the long horizontal sync of a typical 4.3-inch panel, so an off-by-one in the minus-one decoding or a segment dropped from the order shows up as a wrong frame length, sync width or data-enable count. It rewrites the configuration in the middle of a frame; a design that loads it at once would give that frame a mixed length. It checks the first-pixel latency after enable, where a half-length first pixel clock or a frame starting mid-line would shift the count, and the inactive levels after stop under all invert settings, where a design that forgot the invert on one pin would leave it at the wrong level.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

  typedef enum logic [1:0] {
    SEG_SYNC  = 2'd0,
    SEG_BACK  = 2'd1,
    SEG_ACT   = 2'd2,
    SEG_FRONT = 2'd3
  } seg_e;

  function automatic seg_e seg_after(seg_e s);
    case (s)
      SEG_SYNC: return SEG_BACK;
      SEG_BACK: return SEG_ACT;
      SEG_ACT:  return SEG_FRONT;
      default:  return SEG_SYNC;
    endcase
  endfunction

  function automatic int max4(int a, int b, int c, int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/lcdt_pixdiv.sv
module lcdt_pixdiv #(
  parameter int CVW = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run_i,
  input  logic [CVW-1:0] div_i,
  output logic           ph_o,
  output logic           tick_o
);

  logic [CVW-1:0] cnt_q, cnt_d;
  logic           ph_q, ph_d;
  logic           half_end;

  assign half_end = (cnt_q >= div_i);

  always_comb begin
    cnt_d = cnt_q;
    ph_d  = ph_q;
    if (!run_i) begin
      cnt_d = '0;
      ph_d  = 1'b0;
    end else if (half_end) begin
      cnt_d = '0;
      ph_d  = ~ph_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
    end
  end

  assign ph_o   = ph_q;
  assign tick_o = run_i && half_end && !ph_q;

  // R1: the divider never runs past its programmed half period once settled
  assert_half_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && $past(run_i) && $stable(div_i) && cnt_q <= div_i) |=> (cnt_q <= div_i || !$stable(div_i)));

endmodule

// File: rtl/lcdt_axis.sv
module lcdt_axis #(
  parameter int SW = 8,
  parameter int BW = 8,
  parameter int AW = 11,
  parameter int FW = 8,
  localparam int CW = lcdt_pkg::max4(SW, BW, AW, FW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic            step_i,
  input  logic [SW-1:0]   sync_m1_i,
  input  logic [BW-1:0]   back_m1_i,
  input  logic [AW-1:0]   act_m1_i,
  input  logic [FW-1:0]   front_m1_i,
  output lcdt_pkg::seg_e  seg_o,
  output logic [CW-1:0]   cnt_o,
  output logic            wrap_o
);
  import lcdt_pkg::*;

  seg_e          seg_q, seg_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] lim;
  logic          at_end;

  always_comb begin
    case (seg_q)
      SEG_SYNC: lim = CW'(sync_m1_i);
      SEG_BACK: lim = CW'(back_m1_i);
      SEG_ACT:  lim = CW'(act_m1_i);
      default:  lim = CW'(front_m1_i);
    endcase
  end

  assign at_end = (cnt_q == lim);

  always_comb begin
    seg_d = seg_q;
    cnt_d = cnt_q;
    if (clr_i) begin
      seg_d = SEG_SYNC;
      cnt_d = '0;
    end else if (step_i) begin
      if (at_end) begin
        seg_d = seg_after(seg_q);
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q <= SEG_SYNC;
      cnt_q <= '0;
    end else begin
      seg_q <= seg_d;
      cnt_q <= cnt_d;
    end
  end

  assign seg_o  = seg_q;
  assign cnt_o  = cnt_q;
  assign wrap_o = step_i && at_end && (seg_q == SEG_FRONT);

  // R2 R3: segments only ever advance in sync, back, active, front order
  assert_seg_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(seg_q) && !$past(clr_i)) |-> (seg_q == seg_after($past(seg_q))));

  // R4: position inside a segment never exceeds its programmed count
  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= lim);

endmodule

// File: rtl/lcd_raster_gen.sv
module lcd_raster_gen #(
  parameter int CV_W = 10,
  parameter int HS_W = 8,
  parameter int HB_W = 8,
  parameter int HA_W = 11,
  parameter int HF_W = 8,
  parameter int VS_W = 6,
  parameter int VB_W = 8,
  parameter int VA_W = 10,
  parameter int VF_W = 8,
  parameter int DW   = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  input  logic [CV_W-1:0] clkval_i,
  input  logic [HS_W-1:0] hsync_w_i,
  input  logic [HB_W-1:0] hback_i,
  input  logic [HA_W-1:0] hact_i,
  input  logic [HF_W-1:0] hfront_i,
  input  logic [VS_W-1:0] vsync_w_i,
  input  logic [VB_W-1:0] vback_i,
  input  logic [VA_W-1:0] vact_i,
  input  logic [VF_W-1:0] vfront_i,
  input  logic            inv_pclk_i,
  input  logic            inv_hsync_i,
  input  logic            inv_vsync_i,
  input  logic            inv_data_i,
  input  logic            inv_de_i,
  input  logic [DW-1:0]   rgb_i,
  output logic            pclk_o,
  output logic            hsync_o,
  output logic            vsync_o,
  output logic            de_o,
  output logic [DW-1:0]   rgb_o,
  output logic [HA_W-1:0] x_o,
  output logic [VA_W-1:0] y_o,
  output logic            req_o
);
  import lcdt_pkg::*;

  localparam int HCW   = max4(HS_W, HB_W, HA_W, HF_W);
  localparam int VCW   = max4(VS_W, VB_W, VA_W, VF_W);
  localparam int CFG_W = CV_W + HS_W + HB_W + HA_W + HF_W
                       + VS_W + VB_W + VA_W + VF_W + 5;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rs_q;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  // shadow configuration, loaded at frame boundary or while not running
  logic [CFG_W-1:0] cfg_in, shadow_q, shadow_d;
  logic [CV_W-1:0]  clkval_s;
  logic [HS_W-1:0]  hs_s;
  logic [HB_W-1:0]  hb_s;
  logic [HA_W-1:0]  ha_s;
  logic [HF_W-1:0]  hf_s;
  logic [VS_W-1:0]  vs_s;
  logic [VB_W-1:0]  vb_s;
  logic [VA_W-1:0]  va_s;
  logic [VF_W-1:0]  vf_s;
  logic             ipc_s, ihs_s, ivs_s, idat_s, ide_s;

  assign cfg_in = {clkval_i, hsync_w_i, hback_i, hact_i, hfront_i,
                   vsync_w_i, vback_i, vact_i, vfront_i,
                   inv_pclk_i, inv_hsync_i, inv_vsync_i, inv_data_i, inv_de_i};
  assign {clkval_s, hs_s, hb_s, ha_s, hf_s, vs_s, vb_s, va_s, vf_s,
          ipc_s, ihs_s, ivs_s, idat_s, ide_s} = shadow_q;

  logic live_q, live_d;
  logic pix_ph, pix_tick;
  logic h_step, h_wrap, frame_wrap;
  logic jt_q, jt_d;
  seg_e h_seg, v_seg;
  logic [HCW-1:0] h_cnt;
  logic [VCW-1:0] v_cnt;

  lcdt_pixdiv #(.CVW(CV_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_s),
    .run_i  (en_i),
    .div_i  (clkval_s),
    .ph_o   (pix_ph),
    .tick_o (pix_tick)
  );

  assign h_step = pix_tick && live_q;

  lcdt_axis #(.SW(HS_W), .BW(HB_W), .AW(HA_W), .FW(HF_W)) u_hax (
    .clk        (clk),
    .rst_n      (rst_s),
    .clr_i      (!live_q),
    .step_i     (h_step),
    .sync_m1_i  (hs_s),
    .back_m1_i  (hb_s),
    .act_m1_i   (ha_s),
    .front_m1_i (hf_s),
    .seg_o      (h_seg),
    .cnt_o      (h_cnt),
    .wrap_o     (h_wrap)
  );

  lcdt_axis #(.SW(VS_W), .BW(VB_W), .AW(VA_W), .FW(VF_W)) u_vax (
    .clk        (clk),
    .rst_n      (rst_s),
    .clr_i      (!live_q),
    .step_i     (h_wrap),
    .sync_m1_i  (vs_s),
    .back_m1_i  (vb_s),
    .act_m1_i   (va_s),
    .front_m1_i (vf_s),
    .seg_o      (v_seg),
    .cnt_o      (v_cnt),
    .wrap_o     (frame_wrap)
  );

  always_comb begin
    live_d = live_q;
    if (!en_i)         live_d = 1'b0;
    else if (pix_tick) live_d = 1'b1;
    shadow_d = (!live_q || frame_wrap) ? cfg_in : shadow_q;
    jt_d     = h_step;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      live_q   <= 1'b0;
      shadow_q <= '0;
      jt_q     <= 1'b0;
    end else begin
      live_q   <= live_d;
      shadow_q <= shadow_d;
      jt_q     <= jt_d;
    end
  end

  logic de_raw;
  assign de_raw  = live_q && (h_seg == SEG_ACT) && (v_seg == SEG_ACT);

  assign pclk_o  = (live_q && pix_ph) ^ ipc_s;
  assign hsync_o = (live_q && (h_seg == SEG_SYNC)) ^ ihs_s;
  assign vsync_o = (live_q && (v_seg == SEG_SYNC)) ^ ivs_s;
  assign de_o    = de_raw ^ ide_s;
  assign rgb_o   = (de_raw ? rgb_i : '0) ^ {DW{idat_s}};
  assign x_o     = de_raw ? h_cnt[HA_W-1:0] : '0;
  assign y_o     = de_raw ? v_cnt[VA_W-1:0] : '0;
  assign req_o   = jt_q && de_raw;

  // R1: timing advances only where the raw pixel clock turns high
  assert_step_low_R1: assert property (@(posedge clk) disable iff (!rst_s)
    h_step |-> !pix_ph);
  assert_step_rise_R1: assert property (@(posedge clk) disable iff (!rst_s)
    h_step |=> pix_ph);

  // R5: coordinates stay inside the programmed active area
  assert_coord_range_R5: assert property (@(posedge clk) disable iff (!rst_s)
    (de_o != ide_s) |-> (x_o <= ha_s && y_o <= va_s));

  // R6: a request is only raised while data-enable is active
  assert_req_in_de_R6: assert property (@(posedge clk) disable iff (!rst_s)
    req_o |-> (de_o != ide_s));

  // R8: after a stop, sync and data-enable pins rest at their idle levels
  assert_stop_idle_R8: assert property (@(posedge clk) disable iff (!rst_s)
    !en_i |=> (hsync_o == ihs_s && vsync_o == ivs_s && de_o == ide_s && !req_o));

  // R10: the shadow settings hold for the whole of a running frame
  assert_no_tear_R10: assert property (@(posedge clk) disable iff (!rst_s)
    (live_q && !frame_wrap) |=> $stable(shadow_q));

endmodule

// File: tb/test_lcd_raster_gen.sv
module test_lcd_raster_gen;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        en;
  logic [9:0]  clkval;
  logic [7:0]  hs_w, hb, hf, vb, vf;
  logic [10:0] ha;
  logic [5:0]  vs_w;
  logic [9:0]  va;
  logic [4:0]  inv;
  logic [15:0] rgb_in;
  logic        pclk_o, hsync_o, vsync_o, de_o, req_o;
  logic [15:0] rgb_o;
  logic [10:0] x_o;
  logic [9:0]  y_o;

  always #5 clk = ~clk;

  lcd_raster_gen i_lcd_raster_gen (
    .clk(clk), .rst_n(rst_n), .en_i(en), .clkval_i(clkval),
    .hsync_w_i(hs_w), .hback_i(hb), .hact_i(ha), .hfront_i(hf),
    .vsync_w_i(vs_w), .vback_i(vb), .vact_i(va), .vfront_i(vf),
    .inv_pclk_i(inv[4]), .inv_hsync_i(inv[3]), .inv_vsync_i(inv[2]),
    .inv_data_i(inv[1]), .inv_de_i(inv[0]), .rgb_i(rgb_in),
    .pclk_o(pclk_o), .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
    .rgb_o(rgb_o), .x_o(x_o), .y_o(y_o), .req_o(req_o)
  );

  // columns: clkval, hsync, hback, hact, hfront, vsync, vback, vact, vfront, invert mask
  // invert mask bits: [4] pclk [3] hsync [2] vsync [1] data [0] data-enable
  localparam int NV = 4;
  localparam int TBL [NV][10] = '{
    '{0,  2, 1,  4, 1,  1, 2, 3, 1,  0},
    '{2,  1, 1,  1, 1,  1, 1, 1, 1, 31},
    '{1, 41, 2, 16, 2, 10, 2, 4, 2, 12},
    '{0,  3, 2,  7, 3,  2, 1, 2, 3,  0}
  };

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual %0d expected below 150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic apply(int i);
    clkval = 10'(TBL[i][0] );
    hs_w   = 8'(TBL[i][1] - 1);
    hb     = 8'(TBL[i][2] - 1);
    ha     = 11'(TBL[i][3] - 1);
    hf     = 8'(TBL[i][4] - 1);
    vs_w   = 6'(TBL[i][5] - 1);
    vb     = 8'(TBL[i][6] - 1);
    va     = 10'(TBL[i][7] - 1);
    vf     = 8'(TBL[i][8] - 1);
    inv    = 5'(TBL[i][9]);
  endtask

  function automatic logic l_vs();  return vsync_o ^ inv[2]; endfunction
  function automatic logic l_hs();  return hsync_o ^ inv[3]; endfunction
  function automatic logic l_pc();  return pclk_o  ^ inv[4]; endfunction
  function automatic logic l_de();  return de_o    ^ inv[0]; endfunction

  int m_tot, m_pcr, m_pch, m_hsc, m_vsc, m_dec, m_req, m_rgb_bad;
  int m_fx, m_fy, m_lx, m_ly;

  task automatic wait_vs_rise();
    logic prev;
    prev = l_vs();
    forever begin
      @(negedge clk);
      if (l_vs() && !prev) break;
      prev = l_vs();
    end
  endtask

  // counts from the current (rise) sample up to the next vsync rise
  task automatic count_frame(int swap_at, int swap_idx);
    logic prev_pc, prev_vs, seen;
    logic [15:0] exp_rgb;
    m_tot = 0; m_pcr = 0; m_pch = 0; m_hsc = 0; m_vsc = 0;
    m_dec = 0; m_req = 0; m_rgb_bad = 0;
    m_fx = -1; m_fy = -1; m_lx = -1; m_ly = -1;
    prev_pc = 1'b0;
    seen = 1'b0;
    forever begin
      m_tot++;
      if (l_pc() && !prev_pc) m_pcr++;
      if (l_pc()) m_pch++;
      if (l_hs()) m_hsc++;
      if (l_vs()) m_vsc++;
      if (req_o) m_req++;
      if (l_de()) begin
        m_dec++;
        if (!seen) begin m_fx = int'(x_o); m_fy = int'(y_o); seen = 1'b1; end
        m_lx = int'(x_o); m_ly = int'(y_o);
      end
      exp_rgb = (l_de() ? rgb_in : 16'h0) ^ {16{inv[1]}};
      if (rgb_o !== exp_rgb) m_rgb_bad++;
      if (swap_at > 0 && m_tot == swap_at) apply(swap_idx);
      prev_pc = l_pc();
      prev_vs = l_vs();
      @(negedge clk);
      if (l_vs() && !prev_vs) break;
    end
  endtask

  function automatic int htot(int i); return TBL[i][1]+TBL[i][2]+TBL[i][3]+TBL[i][4]; endfunction
  function automatic int vtot(int i); return TBL[i][5]+TBL[i][6]+TBL[i][7]+TBL[i][8]; endfunction
  function automatic int per(int i);  return 2*(TBL[i][0]+1); endfunction

  initial begin
    rst_n = 1'b0;
    en = 1'b0;
    rgb_in = 16'hA5C3;
    apply(0);
    repeat (3) @(negedge clk);
    // reset state, all inverts off: everything low (R8)
    chk("R8 reset pclk",  int'(pclk_o),  0);
    chk("R8 reset hsync", int'(hsync_o), 0);
    chk("R8 reset vsync", int'(vsync_o), 0);
    chk("R8 reset de",    int'(de_o),    0);
    chk("R8 reset req",   int'(req_o),   0);
    chk("R8 reset rgb",   int'(rgb_o),   0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // stopped with every invert set: idle levels all high (R7 R8)
    inv = 5'b11111;
    repeat (2) @(negedge clk);
    chk("R7 idle pclk inverted",  int'(pclk_o),  1);
    chk("R7 idle hsync inverted", int'(hsync_o), 1);
    chk("R7 idle vsync inverted", int'(vsync_o), 1);
    chk("R7 idle de inverted",    int'(de_o),    1);
    chk("R7 idle rgb inverted",   int'(rgb_o),   16'hFFFF);

    // table walk over geometries
    for (int i = 0; i < NV; i++) begin
      en = 1'b0;
      apply(i);
      repeat (3) @(negedge clk);
      en = 1'b1;
      wait_vs_rise();
      count_frame(0, 0);
      chk("R3 R4 frame length",     m_tot, per(i)*htot(i)*vtot(i));
      chk("R1 pixel clock rises",   m_pcr, htot(i)*vtot(i));
      chk("R1 pixel clock high",    m_pch, (TBL[i][0]+1)*htot(i)*vtot(i));
      chk("R2 hsync high cycles",   m_hsc, per(i)*TBL[i][1]*vtot(i));
      chk("R3 vsync high cycles",   m_vsc, per(i)*htot(i)*TBL[i][5]);
      chk("R5 de high cycles",      m_dec, per(i)*TBL[i][3]*TBL[i][7]);
      chk("R6 request count",       m_req, TBL[i][3]*TBL[i][7]);
      chk("R5 first x",             m_fx, 0);
      chk("R5 first y",             m_fy, 0);
      chk("R5 last x",              m_lx, TBL[i][3]-1);
      chk("R5 last y",              m_ly, TBL[i][7]-1);
      chk("R7 rgb path mismatches", m_rgb_bad, 0);
    end

    // R9: latency from enable to frame start, divider value 2
    en = 1'b0;
    apply(1);
    repeat (3) @(negedge clk);
    en = 1'b1;
    begin
      int n;
      n = 0;
      do begin
        @(negedge clk);
        n++;
      end while (!l_vs() && n < 100);
      chk("R9 enable latency", n, TBL[1][0] + 1);
      chk("R9 hsync at start", int'(l_hs()), 1);
      chk("R9 pclk high at start", int'(l_pc()), 1);
    end

    // R8: stop mid-frame, idle one cycle later with inverts applied
    repeat (37) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk("R8 stop hsync idle", int'(hsync_o), 1);
    chk("R8 stop vsync idle", int'(vsync_o), 1);
    chk("R8 stop de idle",    int'(de_o),    1);
    chk("R8 stop pclk idle",  int'(pclk_o),  1);
    chk("R8 stop x",          int'(x_o),     0);
    chk("R8 stop y",          int'(y_o),     0);
    chk("R8 stop req",        int'(req_o),   0);

    // R10: rewrite configuration mid-frame
    apply(0);
    repeat (3) @(negedge clk);
    en = 1'b1;
    wait_vs_rise();
    count_frame(20, 3);
    chk("R10 frame kept old timing", m_tot, per(0)*htot(0)*vtot(0));
    count_frame(0, 0);
    chk("R10 next frame new timing", m_tot, per(3)*htot(3)*vtot(3));
    chk("R10 next frame requests",   m_req, TBL[3][3]*TBL[3][7]);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule